// File: doc/BRIEF.md
# Ternary Column Scaling Accumulator

This unit sits behind a ternary compute array and turns each column's pair of conversion counts into a signed partial sum. The pair consists of `n`, the number of cells that produced +1, and `k`, the number that produced -1. It applies a weight scale and an input scale taken from programmable registers, so the same hardware can serve unweighted, symmetric weighted and asymmetric weighted ternary networks. An asymmetric dot product is formed in two passes, one for the positive inputs and one for the negative inputs. The unit adds the two passes together.

Activations wider than one bit arrive one bit per beat. Each beat's term is shifted left by the significance of its bit. In signed format the top bit counts negatively. Terms from several blocks of the same tile, from both passes and from all activation bits go into one saturating accumulator. A start flag opens the sum. An end flag publishes the result for one cycle. The unit accepts one count pair every cycle, so it can run as the second stage of a pipeline behind the array.

Top module: `tern_scale_acc`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0 and `res_data` is 0. The four scale registers hold 1, the mode is unweighted, the format is signed and the top bit index is 7.
- R2: In unweighted mode (mode field 0, or the reserved value 3), a beat's term is `n - k`. The scale registers and `beat_neg` have no effect on it.
- R3: In symmetric mode (mode field 1), the term is `in_pos_scale * w_pos_scale * (n - k)`. `w_neg_scale`, `in_neg_scale` and `beat_neg` are ignored.
- R4: In asymmetric mode (mode field 2), a beat with `beat_neg`=0 gives `in_pos_scale * (w_pos_scale*n - w_neg_scale*k)`. A beat with `beat_neg`=1 gives `-in_neg_scale * (w_pos_scale*n - w_neg_scale*k)`.
- R5: The result of an asymmetric dot product is the sum of its positive-pass and negative-pass terms.
- R6: Every term is multiplied by 2 raised to `beat_bit` before it is accumulated.
- R7: In signed format (control bit 2 = 0), a beat whose `beat_bit` equals the top bit index (control bits 5:3) is subtracted. In unsigned format (bit 2 = 1), no beat is negated.
- R8: A beat with `beat_first`=1 discards the previous sum. A beat with `beat_last`=1 makes `res_valid` high for exactly the next cycle, and `res_data` then holds the sum including that beat. A beat can carry both flags.
- R9: The accumulator is 24-bit signed and clamps at 8388607 and -8388608 instead of wrapping. Later beats continue from the clamped value.
- R10: Cycles with `beat_valid`=0 leave the accumulator unchanged, whatever the count inputs carry.
- R11: A write with `cfg_we`=1 loads one register, chosen by `cfg_addr`: 0 positive weight scale, 1 negative weight scale, 2 positive input scale, 3 negative input scale, 4 control. The control word holds the mode in bits 1:0, the unsigned flag in bit 2 and the top bit index in bits 5:3. The new value applies from the next cycle.
- R12: Beats are accepted on consecutive cycles. The last beat of one sum can be followed directly by the first beat of the next, and the two results appear on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| beat_valid | input | 1 | Count pair present this cycle |
| beat_pos | input | 4 | Count of +1 cell outputs (n) |
| beat_negc | input | 4 | Count of -1 cell outputs (k) |
| beat_bit | input | 3 | Significance of the activation bit |
| beat_neg | input | 1 | Asymmetric pass select: 0 positive inputs, 1 negative inputs |
| beat_first | input | 1 | Start a new sum with this beat |
| beat_last | input | 1 | Publish the sum after this beat |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Saturated signed result |

## Verification
Opening a sum and closing it can happen on the same beat, and a close can happen on the same edge that starts clamping. The bench provokes the first case with single-beat sums, and also by placing one sum's first beat directly after another sum's last beat. Each result is judged against a term computed from the requirement formulas. The clamp case is provoked with maximum scales at the top bit; both limits are expected, and a follow-up beat must continue from the clamped value rather than from a wrapped one.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [1:0] {
    TM_UNW  = 2'd0,
    TM_SYM  = 2'd1,
    TM_ASYM = 2'd2,
    TM_RSV  = 2'd3
  } tmode_e;

  localparam logic [2:0] RA_WPOS = 3'd0;
  localparam logic [2:0] RA_WNEG = 3'd1;
  localparam logic [2:0] RA_IPOS = 3'd2;
  localparam logic [2:0] RA_INEG = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;
endpackage

// File: rtl/tsa_cfg.sv
module tsa_cfg
  import tsa_pkg::*;
#(
  parameter int SW = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [SW-1:0] data,
  output logic [SW-1:0] wpos,
  output logic [SW-1:0] wneg,
  output logic [SW-1:0] ipos,
  output logic [SW-1:0] ineg,
  output tmode_e        mode,
  output logic          uns,
  output logic [BW-1:0] msb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wpos <= SW'(1);
      wneg <= SW'(1);
      ipos <= SW'(1);
      ineg <= SW'(1);
      mode <= TM_UNW;
      uns  <= 1'b0;
      msb  <= '1;
    end else if (we) begin
      case (addr)
        RA_WPOS: wpos <= data;
        RA_WNEG: wneg <= data;
        RA_IPOS: ipos <= data;
        RA_INEG: ineg <= data;
        RA_CTRL: begin
          mode <= tmode_e'(data[1:0]);
          uns  <= data[2];
          msb  <= data[3 +: BW];
        end
        default: ;
      endcase
    end
  end

  // R11: registers change only on a write
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(wpos) && $stable(wneg) && $stable(ipos) && $stable(ineg)
             && $stable(mode) && $stable(uns) && $stable(msb)));
endmodule

// File: rtl/tsa_scale.sv
module tsa_scale
  import tsa_pkg::*;
#(
  parameter int SW = 8,
  parameter int CW = 4,
  parameter int BW = 3,
  parameter int TW = 32
) (
  input  logic [SW-1:0]        wpos,
  input  logic [SW-1:0]        wneg,
  input  logic [SW-1:0]        ipos,
  input  logic [SW-1:0]        ineg,
  input  tmode_e               mode,
  input  logic                 uns,
  input  logic [BW-1:0]        msb,
  input  logic [CW-1:0]        n,
  input  logic [CW-1:0]        k,
  input  logic [BW-1:0]        bitpos,
  input  logic                 negpass,
  output logic signed [TW-1:0] term
);
  logic [SW-1:0]        wp_sel, wn_sel, is_sel;
  logic                 is_neg;
  logic signed [TW-1:0] wp_x, wn_x, is_x, n_x, k_x, mag, prod, shifted;

  always_comb begin
    case (mode)
      TM_SYM: begin
        wp_sel = wpos; wn_sel = wpos; is_sel = ipos; is_neg = 1'b0;
      end
      TM_ASYM: begin
        wp_sel = wpos; wn_sel = wneg;
        is_sel = negpass ? ineg : ipos;
        is_neg = negpass;
      end
      default: begin
        wp_sel = SW'(1); wn_sel = SW'(1); is_sel = SW'(1); is_neg = 1'b0;
      end
    endcase
  end

  assign wp_x = {{(TW-SW){1'b0}}, wp_sel};
  assign wn_x = {{(TW-SW){1'b0}}, wn_sel};
  assign is_x = is_neg ? -{{(TW-SW){1'b0}}, is_sel} : {{(TW-SW){1'b0}}, is_sel};
  assign n_x  = {{(TW-CW){1'b0}}, n};
  assign k_x  = {{(TW-CW){1'b0}}, k};

  assign mag     = wp_x * n_x - wn_x * k_x;
  assign prod    = is_x * mag;
  assign shifted = prod <<< bitpos;
  assign term    = (!uns && bitpos == msb) ? -shifted : shifted;
endmodule

// File: rtl/tsa_accum.sv
module tsa_accum #(
  parameter int AW = 24,
  parameter int TW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic signed [TW-1:0] term,
  output logic                 res_valid,
  output logic signed [AW-1:0] res_data
);
  localparam int EW = TW + 2;
  localparam logic signed [EW-1:0] MAXV = {{(EW-AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = {{(EW-AW+1){1'b1}}, {(AW-1){1'b0}}};

  logic signed [AW-1:0] acc, acc_nx;
  logic signed [EW-1:0] base, sum;

  assign base = in_first ? '0 : {{(EW-AW){acc[AW-1]}}, acc};
  assign sum  = base + {{(EW-TW){term[TW-1]}}, term};

  always_comb begin
    if (sum > MAXV)      acc_nx = MAXV[AW-1:0];
    else if (sum < MINV) acc_nx = MINV[AW-1:0];
    else                 acc_nx = sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid && in_last;
      if (in_valid) begin
        acc <= acc_nx;
        if (in_last) res_data <= acc_nx;
      end
    end
  end

  // R8: a result strobe only follows a closing beat
  assert_pulse_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_last));
  // R8: a single-beat sum publishes on the next cycle
  assert_single_beat_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first && in_last) |=> res_valid);
  // R10: idle cycles leave the sum alone
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc));
endmodule

// File: rtl/tern_scale_acc.sv
module tern_scale_acc
  import tsa_pkg::*;
#(
  parameter int SW = 8,
  parameter int CW = 4,
  parameter int BW = 3,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [SW-1:0]        cfg_data,
  input  logic                 beat_valid,
  input  logic [CW-1:0]        beat_pos,
  input  logic [CW-1:0]        beat_negc,
  input  logic [BW-1:0]        beat_bit,
  input  logic                 beat_neg,
  input  logic                 beat_first,
  input  logic                 beat_last,
  output logic                 res_valid,
  output logic signed [AW-1:0] res_data
);
  localparam int TW = 2*SW + CW + 3 + (1 << BW);

  logic [SW-1:0]        wpos, wneg, ipos, ineg;
  tmode_e               mode;
  logic                 uns;
  logic [BW-1:0]        msb;
  logic signed [TW-1:0] term;

  tsa_cfg #(.SW(SW), .BW(BW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .wpos(wpos), .wneg(wneg), .ipos(ipos), .ineg(ineg),
    .mode(mode), .uns(uns), .msb(msb)
  );

  tsa_scale #(.SW(SW), .CW(CW), .BW(BW), .TW(TW)) u_scale (
    .wpos(wpos), .wneg(wneg), .ipos(ipos), .ineg(ineg),
    .mode(mode), .uns(uns), .msb(msb),
    .n(beat_pos), .k(beat_negc), .bitpos(beat_bit), .negpass(beat_neg),
    .term(term)
  );

  tsa_accum #(.AW(AW), .TW(TW)) u_acc (
    .clk(clk), .rst(rst), .in_valid(beat_valid), .in_first(beat_first),
    .in_last(beat_last), .term(term), .res_valid(res_valid), .res_data(res_data)
  );

  logic signed [AW-1:0] diff_now;
  assign diff_now = $signed({{(AW-CW){1'b0}}, beat_pos}) - $signed({{(AW-CW){1'b0}}, beat_negc});

  // R2: an unweighted single-beat sum at bit 0 equals n - k
  assert_unweighted_diff_R2: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_first && beat_last && mode == TM_UNW && beat_bit == '0
     && msb != '0 && !cfg_we) |=> (res_data == $past(diff_now)));
endmodule

// File: tb/tern_scale_acc_tb.sv
module tern_scale_acc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic beat_valid = 1'b0, beat_neg = 1'b0, beat_first = 1'b0, beat_last = 1'b0;
  logic [3:0] beat_pos = '0, beat_negc = '0;
  logic [2:0] beat_bit = '0;
  logic res_valid;
  logic signed [23:0] res_data;

  int checks = 0, fails = 0;
  int m_wp = 1, m_wn = 1, m_ip = 1, m_in = 1, m_mode = 0, m_uns = 0, m_msb = 7;

  always #2.5 clk = ~clk;

  tern_scale_acc u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .beat_valid(beat_valid), .beat_pos(beat_pos), .beat_negc(beat_negc),
    .beat_bit(beat_bit), .beat_neg(beat_neg), .beat_first(beat_first),
    .beat_last(beat_last), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mterm(int n, int k, int b, int s);
    longint wp, wn, is, t;
    if (m_mode == 1) begin wp = m_wp; wn = m_wp; is = m_ip; end
    else if (m_mode == 2) begin wp = m_wp; wn = m_wn; is = s ? -m_in : m_ip; end
    else begin wp = 1; wn = 1; is = 1; end
    t = is * (wp * n - wn * k) * (longint'(1) << b);
    if (m_uns == 0 && b == m_msb) t = -t;
    return t;
  endfunction

  function automatic longint sat(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: m_wp = d;
      1: m_wn = d;
      2: m_ip = d;
      3: m_in = d;
      default: begin m_mode = d & 3; m_uns = (d >> 2) & 1; m_msb = (d >> 3) & 7; end
    endcase
  endtask

  task automatic beat(input int n, input int k, input int b, input int s,
                      input bit f, input bit l);
    @(negedge clk);
    beat_valid = 1'b1; beat_pos = 4'(n); beat_negc = 4'(k);
    beat_bit = 3'(b); beat_neg = s[0]; beat_first = f; beat_last = l;
  endtask

  // ends the stream and checks the published result plus pulse width
  task automatic finish_res(input longint exp, input string req);
    @(negedge clk);
    beat_valid = 1'b0; beat_pos = 4'hF; beat_negc = 4'h3;
    chk(res_valid === 1'b1, req, longint'(res_valid), 1);
    chk(longint'(res_data) == exp, req, longint'(res_data), exp);
    @(negedge clk);
    chk(res_valid === 1'b0, "R8", longint'(res_valid), 0);
  endtask

  task automatic t_reset;
    chk(res_valid === 1'b0, "R1", longint'(res_valid), 0);
    chk(res_data === 24'sd0, "R1", longint'(res_data), 0);
    beat(6, 2, 0, 1, 1, 1);
    finish_res(4, "R1");
  endtask

  task automatic t_unweighted;
    wr(0, 9); wr(2, 7);
    beat(5, 2, 0, 1, 1, 0);
    beat(1, 7, 0, 0, 0, 1);
    finish_res(-3, "R2");
    wr(4, 3 | (7 << 3));
    beat(9, 4, 0, 0, 1, 1);
    finish_res(5, "R2");
    wr(4, 7 << 3);
  endtask

  task automatic t_symmetric;
    wr(4, 1 | (7 << 3)); wr(0, 3); wr(1, 50); wr(2, 2); wr(3, 9);
    beat(4, 1, 0, 1, 1, 1);
    finish_res(mterm(4, 1, 0, 1), "R3");
    chk(mterm(4, 1, 0, 1) == 18, "R3", mterm(4, 1, 0, 1), 18);
  endtask

  task automatic t_asym;
    longint e;
    wr(4, 2 | (7 << 3)); wr(0, 3); wr(1, 5); wr(2, 2); wr(3, 4);
    beat(4, 2, 0, 0, 1, 1);
    finish_res(4, "R4");
    beat(1, 3, 0, 1, 1, 1);
    finish_res(48, "R4");
    e = mterm(4, 2, 0, 0) + mterm(1, 3, 0, 1) + mterm(2, 1, 1, 0);
    beat(4, 2, 0, 0, 1, 0);
    beat(1, 3, 0, 1, 0, 0);
    beat(2, 1, 1, 0, 0, 1);
    finish_res(e, "R5");
  endtask

  task automatic t_bitserial;
    wr(4, 3 << 3);
    beat(1, 0, 0, 0, 1, 0);
    beat(1, 0, 1, 0, 0, 0);
    beat(1, 0, 2, 0, 0, 0);
    beat(1, 0, 3, 0, 0, 1);
    finish_res(-1, "R7");
    beat(3, 0, 2, 0, 1, 1);
    finish_res(12, "R6");
    wr(4, 4 | (3 << 3));
    beat(1, 0, 0, 0, 1, 0);
    beat(1, 0, 1, 0, 0, 0);
    beat(1, 0, 2, 0, 0, 0);
    beat(1, 0, 3, 0, 0, 1);
    finish_res(15, "R7");
  endtask

  task automatic t_saturate;
    wr(4, 1 | 4 | (7 << 3)); wr(0, 255); wr(2, 255);
    beat(15, 0, 7, 0, 1, 1);
    finish_res(8388607, "R9");
    beat(15, 0, 7, 0, 1, 0);
    beat(0, 1, 0, 0, 0, 1);
    finish_res(sat(8388607 + mterm(0, 1, 0, 0)), "R9");
    beat(0, 15, 7, 0, 1, 1);
    finish_res(-8388608, "R9");
  endtask

  task automatic t_idle_and_clear;
    wr(4, 7 << 3);
    beat(7, 0, 0, 0, 1, 0);
    @(negedge clk);
    beat_valid = 1'b0; beat_pos = 4'hF; beat_negc = 4'h0; beat_first = 1'b1;
    @(negedge clk);
    beat(0, 2, 0, 0, 0, 1);
    finish_res(5, "R10");
    beat(2, 0, 0, 0, 1, 1);
    finish_res(2, "R8");
  endtask

  task automatic t_back_to_back;
    wr(4, 7 << 3);
    beat(3, 1, 0, 0, 1, 0);
    beat(4, 0, 0, 0, 0, 1);
    beat(0, 9, 0, 0, 1, 1);
    chk(res_valid === 1'b1, "R12", longint'(res_valid), 1);
    chk(longint'(res_data) == 6, "R12", longint'(res_data), 6);
    finish_res(-9, "R12");
  endtask

  task automatic t_cfg_timing;
    wr(4, 1 | (7 << 3)); wr(0, 2); wr(2, 1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_data = 8'd10;
    beat_valid = 1'b1; beat_pos = 4'd1; beat_negc = 4'd0; beat_bit = '0;
    beat_neg = 1'b0; beat_first = 1'b1; beat_last = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; m_wp = 10;
    beat_first = 1'b0; beat_last = 1'b1;
    finish_res(12, "R11");
  endtask

  initial begin
    #(5.0 * 20000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unweighted();
    t_symmetric();
    t_asym();
    t_bitserial();
    t_saturate();
    t_idle_and_clear();
    t_back_to_back();
    t_cfg_timing();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule